// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block produces the bit timing for a UART transmitter and a UART receiver. Each side receives a tick at every sixteenth of a bit and a pulse at every bit boundary. The basic bit width comes from an integer divisor that both sides share. Each bit position in the frame also has a 2-bit jitter code. The code can make that one bit one sixteenth longer or shorter. Spreading these small corrections across the frame keeps the frame's total length close to the ideal rate, even when the divisor alone would round it badly.

Each side is armed by a one-cycle start pulse. From that pulse it counts the bits of one frame and then goes idle. The frame length comes from the line format: the data-bit count, whether a parity bit is present, and the stop-bit count. The transmit and receive sides run independently. Each has its own start pulse and its own jitter pattern, and both share the divisor and the line format. All configuration inputs are expected to stay stable while a side is busy.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first start pulse, every tick, bit-end and busy output is 0 and both bit indices are 0.
- R2: The divider input holds the divisor minus one, so a value v gives D = v + 1 clocks per oversample slot. A bit whose jitter code is none lasts exactly 16·D clocks.
- R3: Within a bit that begins at clock offset s, an oversample tick is high for one cycle at offsets s + j·D for j = 1..15, and also at the bit's end. Every bit-end pulse coincides with a tick. The first tick of a frame appears D cycles after the clock edge that samples the start pulse.
- R4: The jitter code of bit position i sits in bits [2i+1:2i] of that side's pattern. Code 2'b01 (increment) makes the bit 17·D clocks long by doubling its last slot. Code 2'b10 (decrement) makes it 15·D clocks long by dropping its last slot. Codes 2'b00 and 2'b11 leave the width at 16·D.
- R5: The frame holds 1 start bit, plus the data bits, plus 1 parity bit when parity is present, plus the stop bits. The 2-bit data field gives value + 5 data bits. The 1-bit stop field gives value + 1 stop bits. The 3-bit parity mode uses 0 = none, 1 = even, 2 = odd, 3 = forced one and 4 = forced zero, and any nonzero value adds a parity bit. Busy falls in the same cycle as the frame's last bit-end pulse, and no tick or bit-end pulse follows while the side stays idle.
- R6: A start pulse restarts its side even in the middle of a frame. From the next cycle, busy is 1, the bit index is 0 and all timing is measured from that start.
- R7: The transmit and receive sides keep their own timing. Each uses only its own start pulse and its own pattern, and both use the shared divider and line format.
- R8: The bit index output equals the number of bits completed since the last start. It steps by one with each bit-end pulse and holds the frame length after the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div_i | input | 8 | Divisor minus one, shared |
| cfg_dbits_i | input | 2 | Data bits minus five |
| cfg_parity_i | input | 3 | Parity mode, nonzero adds a bit |
| cfg_stop_i | input | 1 | Stop bits minus one |
| tx_jit_i | input | 24 | Transmit jitter pattern, 2 bits per position |
| rx_jit_i | input | 24 | Receive jitter pattern, 2 bits per position |
| tx_start_i | input | 1 | Transmit frame start pulse |
| rx_start_i | input | 1 | Receive frame start pulse |
| tx_tick_o | output | 1 | Transmit oversample tick |
| tx_bit_end_o | output | 1 | Transmit bit boundary pulse |
| tx_busy_o | output | 1 | Transmit frame in progress |
| tx_bit_idx_o | output | 4 | Transmit bits completed |
| rx_tick_o | output | 1 | Receive oversample tick |
| rx_bit_end_o | output | 1 | Receive bit boundary pulse |
| rx_busy_o | output | 1 | Receive frame in progress |
| rx_bit_idx_o | output | 4 | Receive bits completed |

## Verification
Directed frames fill every position with one code: all none, all decrement at the smallest divisor, all increment on the longest frame, and the reserved code. This separates the three bit widths from one another and shows that the reserved code acts like none. Randomized divisors, line formats and patterns, with the receive start offset from the transmit start, check the tick and boundary positions cycle by cycle against a bench model. They also compare each side's measured frame length with the sum of its bit widths, which exposes any pattern mix-up between the sides. A restart in the middle of a frame and a run at the largest divisor test the restart rule and the counter's range.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

  typedef enum logic [1:0] {
    JIT_NONE = 2'b00,
    JIT_INC  = 2'b01,
    JIT_DEC  = 2'b10,
    JIT_RSVD = 2'b11
  } jit_code_e;

  localparam int SLOTS_PER_BIT = 16;

  // Number of bits in one frame for a given line format.
  function automatic logic [3:0] frame_bits(input logic [1:0] dbits,
                                            input logic [2:0] par,
                                            input logic       stop);
    logic [3:0] n;
    n = 4'd1;                          // start bit
    n = n + 4'(dbits) + 4'd5;          // data bits
    n = n + ((par != 3'd0) ? 4'd1 : 4'd0);
    n = n + 4'(stop) + 4'd1;           // stop bits
    return n;
  endfunction

endpackage

// File: rtl/fbg_frame_len.sv
module fbg_frame_len
  import fbg_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [1:0]       dbits_i,
  input  logic [2:0]       parity_i,
  input  logic             stop_i,
  output logic [IDX_W-1:0] len_o
);

  logic [3:0] bits_raw;

  always_comb begin
    bits_raw = frame_bits(dbits_i, parity_i, stop_i);
    len_o    = IDX_W'(bits_raw);
  end

endmodule

// File: rtl/fbg_jit_pick.sv
module fbg_jit_pick
  import fbg_pkg::*;
#(
  parameter int NPOS  = 12,
  parameter int IDX_W = 4
) (
  input  logic [2*NPOS-1:0] pat_i,
  input  logic [IDX_W-1:0]  idx_i,
  output jit_code_e         code_o
);

  logic [1:0] pos_code [NPOS];

  for (genvar g = 0; g < NPOS; g++) begin : g_pos
    assign pos_code[g] = pat_i[2*g +: 2];
  end

  // Positions past the pattern and the reserved code both mean "none".
  always_comb begin
    code_o = JIT_NONE;
    for (int i = 0; i < NPOS; i++) begin
      if (idx_i == IDX_W'(i)) code_o = jit_code_e'(pos_code[i]);
    end
    if (code_o == JIT_RSVD) code_o = JIT_NONE;
  end

endmodule

// File: rtl/fbg_path.sv
module fbg_path
  import fbg_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int NPOS  = 12,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [2*NPOS-1:0] pat_i,
  input  logic [IDX_W-1:0]  len_i,
  input  logic              start_i,
  output logic              tick_o,
  output logic              bit_end_o,
  output logic              busy_o,
  output logic [IDX_W-1:0]  bit_idx_o
);

  localparam int CW = DIV_W + 2;
  localparam logic [3:0] LAST_SLOT  = 4'(SLOTS_PER_BIT - 1);
  localparam logic [3:0] SHORT_SLOT = 4'(SLOTS_PER_BIT - 2);

  // Last count value of a slot; a stretched slot lasts two divisors.
  function automatic logic [CW-1:0] slot_last(input logic [CW-1:0] d,
                                              input logic          stretch);
    return stretch ? ((d << 1) - CW'(1)) : (d - CW'(1));
  endfunction

  logic [CW-1:0]    cnt_q;
  logic [3:0]       slot_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;
  logic             tick_q;
  logic             end_q;

  jit_code_e        code;
  logic [CW-1:0]    d_val;
  logic [CW-1:0]    cnt_last;
  logic             stretch;
  logic             shrink_end;
  logic             slot_ev;
  logic             bit_ev;
  logic             last_bit;

  fbg_jit_pick #(.NPOS(NPOS), .IDX_W(IDX_W)) u_pick (
    .pat_i (pat_i),
    .idx_i (idx_q),
    .code_o(code)
  );

  always_comb begin
    d_val      = CW'(div_i) + CW'(1);
    stretch    = (slot_q == LAST_SLOT) && (code == JIT_INC);
    cnt_last   = slot_last(d_val, stretch);
    slot_ev    = busy_q && (cnt_q == cnt_last);
    shrink_end = (slot_q == SHORT_SLOT) && (code == JIT_DEC);
    bit_ev     = slot_ev && ((slot_q == LAST_SLOT) || shrink_end);
    last_bit   = (idx_q == (len_i - IDX_W'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      slot_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (slot_ev) begin
        cnt_q <= '0;
        if (bit_ev) begin
          slot_q <= '0;
          idx_q  <= idx_q + IDX_W'(1);
          if (last_bit) busy_q <= 1'b0;
        end else begin
          slot_q <= slot_q + 4'd1;
        end
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      tick_q <= slot_ev;
      end_q  <= bit_ev;
    end
  end

  assign tick_o    = tick_q;
  assign bit_end_o = end_q;
  assign busy_o    = busy_q;
  assign bit_idx_o = idx_q;

  // R3: every boundary lands on an oversample tick
  p_end_has_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end_o |-> tick_o);

  // R5: an idle side stays quiet until a start arrives
  p_quiet_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> (!tick_o && !bit_end_o));

  // R5: busy only drops together with a boundary pulse
  p_busy_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> bit_end_o);

  // R6: a start always restarts at bit zero
  p_start_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_o && (bit_idx_o == '0)));

  // R8: the index advances by one per boundary
  p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end_o && !$past(start_i)) |-> (bit_idx_o == $past(bit_idx_o) + IDX_W'(1)));

  // R2: the slot counter never passes a doubled divisor
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt_q < (d_val << 1)));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int NPOS  = 12,
  parameter int IDX_W = $clog2(NPOS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic [1:0]        cfg_dbits_i,
  input  logic [2:0]        cfg_parity_i,
  input  logic              cfg_stop_i,
  input  logic [2*NPOS-1:0] tx_jit_i,
  input  logic [2*NPOS-1:0] rx_jit_i,
  input  logic              tx_start_i,
  input  logic              rx_start_i,
  output logic              tx_tick_o,
  output logic              tx_bit_end_o,
  output logic              tx_busy_o,
  output logic [IDX_W-1:0]  tx_bit_idx_o,
  output logic              rx_tick_o,
  output logic              rx_bit_end_o,
  output logic              rx_busy_o,
  output logic [IDX_W-1:0]  rx_bit_idx_o
);

  localparam int NPATH = 2;

  logic [IDX_W-1:0]  frame_len;
  logic [2*NPOS-1:0] pat_v   [NPATH];
  logic              start_v [NPATH];
  logic              tick_v  [NPATH];
  logic              end_v   [NPATH];
  logic              busy_v  [NPATH];
  logic [IDX_W-1:0]  idx_v   [NPATH];

  fbg_frame_len #(.IDX_W(IDX_W)) u_len (
    .dbits_i (cfg_dbits_i),
    .parity_i(cfg_parity_i),
    .stop_i  (cfg_stop_i),
    .len_o   (frame_len)
  );

  assign pat_v[0]   = tx_jit_i;
  assign pat_v[1]   = rx_jit_i;
  assign start_v[0] = tx_start_i;
  assign start_v[1] = rx_start_i;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    fbg_path #(.DIV_W(DIV_W), .NPOS(NPOS), .IDX_W(IDX_W)) u_path (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_i    (cfg_div_i),
      .pat_i    (pat_v[p]),
      .len_i    (frame_len),
      .start_i  (start_v[p]),
      .tick_o   (tick_v[p]),
      .bit_end_o(end_v[p]),
      .busy_o   (busy_v[p]),
      .bit_idx_o(idx_v[p])
    );
  end

  assign tx_tick_o    = tick_v[0];
  assign tx_bit_end_o = end_v[0];
  assign tx_busy_o    = busy_v[0];
  assign tx_bit_idx_o = idx_v[0];
  assign rx_tick_o    = tick_v[1];
  assign rx_bit_end_o = end_v[1];
  assign rx_busy_o    = busy_v[1];
  assign rx_bit_idx_o = idx_v[1];

endmodule

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;

  localparam int DIV_W = 8;
  localparam int NPOS  = 12;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [DIV_W-1:0]  cfg_div = '0;
  logic [1:0]        cfg_dbits = '0;
  logic [2:0]        cfg_parity = '0;
  logic              cfg_stop = 1'b0;
  logic [2*NPOS-1:0] tx_jit = '0;
  logic [2*NPOS-1:0] rx_jit = '0;
  logic              tx_start = 1'b0;
  logic              rx_start = 1'b0;
  logic              tx_tick, tx_end, tx_busy, rx_tick, rx_end, rx_busy;
  logic [IDX_W-1:0]  tx_idx, rx_idx;

  frac_baud_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_div_i(cfg_div), .cfg_dbits_i(cfg_dbits),
    .cfg_parity_i(cfg_parity), .cfg_stop_i(cfg_stop),
    .tx_jit_i(tx_jit), .rx_jit_i(rx_jit),
    .tx_start_i(tx_start), .rx_start_i(rx_start),
    .tx_tick_o(tx_tick), .tx_bit_end_o(tx_end), .tx_busy_o(tx_busy),
    .tx_bit_idx_o(tx_idx),
    .rx_tick_o(rx_tick), .rx_bit_end_o(rx_end), .rx_busy_o(rx_busy),
    .rx_bit_idx_o(rx_idx)
  );

  int checks = 0;
  int fails = 0;
  longint cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d",
               req, what, cyc, act, exp);
    end
  endtask

  // ---- bench-side arithmetic ----
  function automatic int code_at(input logic [2*NPOS-1:0] pat, input int i);
    int c;
    if (i >= NPOS) return 0;
    c = int'(pat[2*i +: 2]);
    return (c == 1 || c == 2) ? c : 0;
  endfunction

  function automatic int width_of(input int d, input int c);
    if (c == 1) return 17 * d;
    if (c == 2) return 15 * d;
    return 16 * d;
  endfunction

  function automatic int bits_in_frame();
    return 1 + (int'(cfg_dbits) + 5) + ((cfg_parity != 0) ? 1 : 0) + (int'(cfg_stop) + 1);
  endfunction

  function automatic int frame_clocks(input logic [2*NPOS-1:0] pat);
    int t = 0;
    for (int i = 0; i < bits_in_frame(); i++)
      t += width_of(int'(cfg_div) + 1, code_at(pat, i));
    return t;
  endfunction

  // ---- cycle model ----
  bit     m_act [2];
  int     m_off [2];
  int     m_bit [2];
  int     m_len [2];
  longint m_t0  [2];
  longint last_dur [2];

  task automatic step(input int p, input logic st, input logic tk, input logic be,
                      input logic bz, input logic [IDX_W-1:0] ix,
                      input logic [2*NPOS-1:0] pat);
    int d, w, c;
    bit exp_end, exp_tick;
    d = int'(cfg_div) + 1;
    if (st) begin
      m_act[p] = 1; m_off[p] = 0; m_bit[p] = 0;
      m_len[p] = bits_in_frame(); m_t0[p] = cyc;
      check(bz == 1'b1, "R6", "busy after start", bz, 1);
      check(ix == '0, "R6", "index after start", ix, 0);
    end else if (m_act[p]) begin
      m_off[p]++;
      c = code_at(pat, m_bit[p]);
      w = width_of(d, c);
      exp_end  = (m_off[p] == w);
      exp_tick = exp_end || ((m_off[p] % d == 0) && (m_off[p] / d <= 15));
      check(tk == exp_tick, "R3", "oversample tick", tk, exp_tick);
      check(be == exp_end, (c == 0) ? "R2" : "R4", "bit end", be, exp_end);
      if (exp_end) begin
        m_bit[p]++; m_off[p] = 0;
        if (m_bit[p] == m_len[p]) begin
          m_act[p] = 0;
          last_dur[p] = cyc - m_t0[p];
        end
      end
      check(bz == m_act[p], "R5", "busy", bz, m_act[p]);
      check(int'(ix) == m_bit[p], "R8", "bit index", ix, m_bit[p]);
    end else begin
      check(tk == 1'b0 && be == 1'b0 && bz == 1'b0, "R5", "idle quiet",
            {tk, be, bz}, 0);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      cyc++;
      step(0, tx_start, tx_tick, tx_end, tx_busy, tx_idx, tx_jit);
      step(1, rx_start, rx_tick, rx_end, rx_busy, rx_idx, rx_jit);
    end
  end

  // ---- stimulus helpers ----
  task automatic pulse(input int p);
    @(negedge clk);
    if (p == 0) tx_start = 1'b1; else rx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0; rx_start = 1'b0;
  endtask

  task automatic pulse_both();
    @(negedge clk);
    tx_start = 1'b1; rx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0; rx_start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (tx_busy || rx_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input int dv, input int db, input int pr, input int sp,
                         input logic [2*NPOS-1:0] tp, input logic [2*NPOS-1:0] rp);
    @(negedge clk);
    cfg_div = DIV_W'(dv); cfg_dbits = 2'(db); cfg_parity = 3'(pr);
    cfg_stop = 1'(sp); tx_jit = tp; rx_jit = rp;
  endtask

  task automatic run_tx(input string req);
    pulse(0);
    wait_idle();
    check(last_dur[0] == longint'(frame_clocks(tx_jit)), req, "tx frame length",
          last_dur[0], frame_clocks(tx_jit));
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!tx_tick && !tx_end && !tx_busy && !rx_tick && !rx_end && !rx_busy,
          "R1", "outputs in reset", {tx_tick, tx_end, tx_busy, rx_tick, rx_end, rx_busy}, 0);
    check(tx_idx == '0 && rx_idx == '0, "R1", "indices in reset", {tx_idx, rx_idx}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!tx_busy && !rx_busy && !tx_tick && !rx_tick, "R1", "idle after reset",
          {tx_busy, rx_busy, tx_tick, rx_tick}, 0);

    // R2: all-none, smallest frame
    set_cfg(2, 0, 0, 0, '0, '0);
    run_tx("R2");
    check(int'(tx_idx) == 7, "R8", "index holds frame length", tx_idx, 7);

    // R4: all decrement, divisor of one
    set_cfg(0, 1, 1, 0, {NPOS{2'b10}}, '0);
    run_tx("R4");
    // R4: all increment, longest frame, parity mode 7 counts as present (R5)
    set_cfg(3, 3, 7, 1, {NPOS{2'b01}}, '0);
    run_tx("R5");
    check(int'(tx_idx) == 12, "R5", "12-bit frame count", tx_idx, 12);
    // R4: reserved code acts as none
    set_cfg(1, 2, 2, 1, {NPOS{2'b11}}, '0);
    run_tx("R4");

    // R6: restart mid-frame
    set_cfg(1, 3, 0, 0, 24'h5a69a5, '0);
    pulse(0);
    repeat (45) @(negedge clk);
    pulse(0);
    wait_idle();
    check(last_dur[0] == longint'(frame_clocks(tx_jit)), "R6", "frame after restart",
          last_dur[0], frame_clocks(tx_jit));

    // R7: both sides at once, different patterns
    set_cfg(2, 3, 1, 1, {NPOS{2'b01}}, {NPOS{2'b10}});
    pulse_both();
    wait_idle();
    check(last_dur[0] == longint'(frame_clocks(tx_jit)), "R7", "tx length, dual run",
          last_dur[0], frame_clocks(tx_jit));
    check(last_dur[1] == longint'(frame_clocks(rx_jit)), "R7", "rx length, dual run",
          last_dur[1], frame_clocks(rx_jit));

    // Random frames on both sides with offset starts
    for (int n = 0; n < 30; n++) begin
      int dly;
      set_cfg($urandom_range(0, 6), $urandom_range(0, 3), $urandom_range(0, 5),
              $urandom_range(0, 1), 24'($urandom), 24'($urandom));
      dly = $urandom_range(0, 40);
      pulse(0);
      repeat (dly) @(negedge clk);
      pulse(1);
      wait_idle();
      check(last_dur[0] == longint'(frame_clocks(tx_jit)), "R7", "tx random frame",
            last_dur[0], frame_clocks(tx_jit));
      check(last_dur[1] == longint'(frame_clocks(rx_jit)), "R7", "rx random frame",
            last_dur[1], frame_clocks(rx_jit));
    end

    // R2: largest divisor, short frame
    set_cfg(255, 0, 0, 0, 24'h000009, '0);
    run_tx("R2");

    finish_up();
  end

endmodule